// File: doc/BRIEF.md
# General-Purpose I/O Bank with Edge Event Status

This block is a bank of general-purpose pins. Each pin has its own controls for direction, polarity and output buffer type. Each pin also has an enable that turns either-edge event detection on. The pad input passes through a synchronizer before anything uses it. Software reads the pin level after the synchronizer, corrected for polarity. In output mode, the pad is driven from a data bit.

When a pin with edge detection enabled changes level, the bank latches two sticky status flags for that pin: a wake flag and an interrupt flag. Software clears each flag by pulsing a write-one-to-clear input. The interrupt flags are masked per pin and ORed together. A global enable then gates the result onto a single active-low interrupt pad. The idle level of that pad depends on its buffer type. As open-drain, it is released while idle. As push-pull, it is driven high while idle.

Configuration and clear inputs are plain ports that a register file elsewhere drives. No host bus protocol is part of this block.

Top module: `gpio_evt_bank`

## Requirements
- R1: While reset is asserted and after it is released, every wake and interrupt status flag reads 0 until a qualifying pin edge occurs.
- R2: `pin_val[i]` equals the pad input of pin i XOR `cfg_pol[i]`. A pad change is visible after SYNC_STAGES (default 2) rising clock edges, and not before.
- R3: The pad output is set as follows:
  - With `cfg_dir[i]`=0 (input), the pad is released: `pad_oe[i]`=0.
  - With `cfg_dir[i]`=1 (output), the logical value is `dout[i]` XOR `cfg_pol[i]`.
  - For push-pull (`cfg_od[i]`=0), `pad_o` carries that value and `pad_oe`=1.
  - For open-drain (`cfg_od[i]`=1), `pad_o`=0 and `pad_oe` is the inverse of that value.
- R4: With `edge_en[i]`=1, both a rising and a falling pad transition set both `pme_sts[i]` and `smi_sts[i]`. The flags set on rising clock edge SYNC_STAGES+1 after the pad change. With `edge_en[i]`=0, no flag is set.
- R5: `cfg_pol[i]` has no effect on edge detection. An edge is taken from the pad level before inversion.
- R6: Status flags are sticky. A one-cycle pulse on `pme_clr[i]` or `smi_clr[i]` clears only that flag of that pin, at the next rising clock edge. A clear of a flag that is already 0 changes nothing.
- R7: If a new edge and a clear of the same flag reach the same clock edge, the flag ends set.
- R8: The interrupt is active only when some `smi_sts[i] & smi_en[i]` is 1 and `smi_gen`=1. Otherwise it is inactive.
- R9: With `smi_od`=1, the interrupt pad uses `smi_n_oe`=0 while inactive. While active, it uses `smi_n_o`=0 with `smi_n_oe`=1.
- R10: With `smi_od`=0, the interrupt pad has `smi_n_oe`=1 and `smi_n_o` equal to the inverse of the active state, so it is high while inactive.
- R11: A pad that is already at 1 when reset is released produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | NPINS | Raw pad inputs |
| cfg_dir | input | NPINS | 1 = output, 0 = input |
| cfg_pol | input | NPINS | 1 = inverted |
| cfg_od | input | NPINS | 1 = open-drain, 0 = push-pull |
| edge_en | input | NPINS | Either-edge event enable |
| dout | input | NPINS | Output data bits |
| smi_en | input | NPINS | Per-pin interrupt mask (1 = enabled) |
| smi_gen | input | 1 | Global interrupt enable |
| smi_od | input | 1 | Interrupt pad buffer type, 1 = open-drain |
| pme_clr | input | NPINS | Write-one-to-clear pulses for wake flags |
| smi_clr | input | NPINS | Write-one-to-clear pulses for interrupt flags |
| pad_o | output | NPINS | Pad output data |
| pad_oe | output | NPINS | Pad output enable |
| pin_val | output | NPINS | Synchronized, polarity-corrected pin level |
| pme_sts | output | NPINS | Sticky wake flags |
| smi_sts | output | NPINS | Sticky interrupt flags |
| smi_n_o | output | 1 | Active-low interrupt pad data |
| smi_n_oe | output | 1 | Interrupt pad output enable |

## Verification
The bench holds a pad high through reset. A design that treats the first synchronized sample as a transition would raise a spurious event there. The bench inverts polarity before a falling edge, so a detector placed after the inverter would still fire but would mistime or miss edges with other polarity mixes. The bench also lines a clear pulse up with the clock edge that latches a fresh event, so a clear-wins priority would drop the flag. Finally, it sweeps both interrupt buffer types with mask and global enable on and off. A design that drives an open-drain pad high, or releases a push-pull pad, is caught at the pins.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

   typedef struct packed {
      logic dir;      // 1 = output
      logic pol;      // 1 = inverted
      logic od;       // 1 = open-drain
      logic edge_en;  // either-edge detection
   } pin_cfg_t;

   localparam int unsigned MIN_SYNC = 2;
   localparam int unsigned MAX_PINS = 32;

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic armed
);
   localparam int unsigned ARM_W = STAGES + 1;

   logic [STAGES-1:0] chain;
   logic [ARM_W-1:0]  arm_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= '0;
         arm_sr <= '0;
      end else begin
         chain  <= {chain[STAGES-2:0], d};
         arm_sr <= {arm_sr[ARM_W-2:0], 1'b1};
      end
   end

   assign q     = chain[STAGES-1];
   assign armed = arm_sr[ARM_W-1];
endmodule

// File: rtl/gpio_evt_pin.sv
module gpio_evt_pin
   import gpio_evt_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  pin_cfg_t cfg,
   input  logic     dout,
   input  logic     pad_i,
   input  logic     pme_clr,
   input  logic     smi_clr,
   output logic     pad_o,
   output logic     pad_oe,
   output logic     pin_val,
   output logic     pme_sts,
   output logic     smi_sts
);
   logic sync_q, armed, prev_q, edge_hit, drv_val;

   gpio_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_i),
      .q     (sync_q),
      .armed (armed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q;
   end

   // Raw level is compared: polarity plays no part in detection.
   assign edge_hit = armed & cfg.edge_en & (sync_q ^ prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pme_sts <= 1'b0;
         smi_sts <= 1'b0;
      end else begin
         pme_sts <= edge_hit | (pme_sts & ~pme_clr);
         smi_sts <= edge_hit | (smi_sts & ~smi_clr);
      end
   end

   assign pin_val = sync_q ^ cfg.pol;
   assign drv_val = dout ^ cfg.pol;

   always_comb begin
      pad_o  = 1'b0;
      pad_oe = 1'b0;
      if (cfg.dir) begin
         if (cfg.od) begin
            pad_oe = ~drv_val;
         end else begin
            pad_o  = drv_val;
            pad_oe = 1'b1;
         end
      end
   end
endmodule

// File: rtl/gpio_evt_smi_out.sv
module gpio_evt_smi_out #(
   parameter int unsigned NPINS = 4
) (
   input  logic [NPINS-1:0] smi_sts,
   input  logic [NPINS-1:0] smi_en,
   input  logic             smi_gen,
   input  logic             smi_od,
   output logic             smi_n_o,
   output logic             smi_n_oe
);
   logic active;

   assign active = (|(smi_sts & smi_en)) & smi_gen;

   always_comb begin
      if (smi_od) begin
         smi_n_o  = 1'b0;
         smi_n_oe = active;
      end else begin
         smi_n_o  = ~active;
         smi_n_oe = 1'b1;
      end
   end
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
   import gpio_evt_pkg::*;
#(
   parameter int unsigned NPINS       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pad_i,
   input  logic [NPINS-1:0] cfg_dir,
   input  logic [NPINS-1:0] cfg_pol,
   input  logic [NPINS-1:0] cfg_od,
   input  logic [NPINS-1:0] edge_en,
   input  logic [NPINS-1:0] dout,
   input  logic [NPINS-1:0] smi_en,
   input  logic             smi_gen,
   input  logic             smi_od,
   input  logic [NPINS-1:0] pme_clr,
   input  logic [NPINS-1:0] smi_clr,
   output logic [NPINS-1:0] pad_o,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pin_val,
   output logic [NPINS-1:0] pme_sts,
   output logic [NPINS-1:0] smi_sts,
   output logic             smi_n_o,
   output logic             smi_n_oe
);
   if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
      $error("gpio_evt_bank: NPINS out of range");
   end
   if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
      $error("gpio_evt_bank: SYNC_STAGES below minimum");
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      pin_cfg_t cfg;
      assign cfg = '{dir: cfg_dir[i], pol: cfg_pol[i], od: cfg_od[i], edge_en: edge_en[i]};

      gpio_evt_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg     (cfg),
         .dout    (dout[i]),
         .pad_i   (pad_i[i]),
         .pme_clr (pme_clr[i]),
         .smi_clr (smi_clr[i]),
         .pad_o   (pad_o[i]),
         .pad_oe  (pad_oe[i]),
         .pin_val (pin_val[i]),
         .pme_sts (pme_sts[i]),
         .smi_sts (smi_sts[i])
      );
   end

   gpio_evt_smi_out #(.NPINS(NPINS)) u_smi (
      .smi_sts  (smi_sts),
      .smi_en   (smi_en),
      .smi_gen  (smi_gen),
      .smi_od   (smi_od),
      .smi_n_o  (smi_n_o),
      .smi_n_oe (smi_n_oe)
   );
endmodule

// File: rtl/gpio_evt_bank_chk.sv
module gpio_evt_bank_chk #(
   parameter int unsigned NPINS = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] cfg_dir,
   input logic [NPINS-1:0] cfg_od,
   input logic [NPINS-1:0] edge_en,
   input logic [NPINS-1:0] smi_en,
   input logic             smi_gen,
   input logic             smi_od,
   input logic [NPINS-1:0] pme_clr,
   input logic [NPINS-1:0] smi_clr,
   input logic [NPINS-1:0] pad_o,
   input logic [NPINS-1:0] pad_oe,
   input logic [NPINS-1:0] pme_sts,
   input logic [NPINS-1:0] smi_sts,
   input logic             smi_n_o,
   input logic             smi_n_oe
);
   AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~cfg_dir) == '0); // R3
   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_o & pad_oe & cfg_od) == '0); // R3
   AST_SMI_OD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (smi_od && !smi_gen) |-> !smi_n_oe); // R9
   AST_SMI_PP_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !smi_od |-> smi_n_oe); // R10
   AST_SMI_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((smi_sts & smi_en) == '0) |-> (smi_od ? !smi_n_oe : smi_n_o)); // R8

   for (genvar i = 0; i < NPINS; i++) begin : g_bit
      AST_PME_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pme_sts[i]) |-> $past(edge_en[i])); // R4
      AST_PME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (pme_sts[i] && !pme_clr[i]) |=> pme_sts[i]); // R6
      AST_SMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (smi_sts[i] && !smi_clr[i]) |=> smi_sts[i]); // R6
   end
endmodule

bind gpio_evt_bank gpio_evt_bank_chk #(.NPINS(NPINS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_dir  (cfg_dir),
   .cfg_od   (cfg_od),
   .edge_en  (edge_en),
   .smi_en   (smi_en),
   .smi_gen  (smi_gen),
   .smi_od   (smi_od),
   .pme_clr  (pme_clr),
   .smi_clr  (smi_clr),
   .pad_o    (pad_o),
   .pad_oe   (pad_oe),
   .pme_sts  (pme_sts),
   .smi_sts  (smi_sts),
   .smi_n_o  (smi_n_o),
   .smi_n_oe (smi_n_oe)
);

// File: tb/gpio_evt_bank_tb.sv
module gpio_evt_bank_tb;
   localparam int unsigned NPINS = 4;
   localparam int unsigned NVEC  = 12;
   // {dir, pol, od, dout, exp_o, exp_oe}
   localparam logic [5:0] DRV_VEC [NVEC] = '{
      6'b0000_00, 6'b0101_00, 6'b0011_00, 6'b1000_01,
      6'b1001_11, 6'b1100_11, 6'b1101_01, 6'b1010_01,
      6'b1011_00, 6'b1110_00, 6'b1111_01, 6'b1000_01
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NPINS-1:0] pad_i, cfg_dir, cfg_pol, cfg_od, edge_en, dout, smi_en, pme_clr, smi_clr;
   logic smi_gen, smi_od;
   logic [NPINS-1:0] pad_o, pad_oe, pin_val, pme_sts, smi_sts;
   logic smi_n_o, smi_n_oe;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_evt_bank #(.NPINS(NPINS), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .cfg_dir(cfg_dir), .cfg_pol(cfg_pol),
      .cfg_od(cfg_od), .edge_en(edge_en), .dout(dout), .smi_en(smi_en),
      .smi_gen(smi_gen), .smi_od(smi_od), .pme_clr(pme_clr), .smi_clr(smi_clr),
      .pad_o(pad_o), .pad_oe(pad_oe), .pin_val(pin_val), .pme_sts(pme_sts),
      .smi_sts(smi_sts), .smi_n_o(smi_n_o), .smi_n_oe(smi_n_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      pad_i = 4'b0010; cfg_dir = '0; cfg_pol = '0; cfg_od = '0; edge_en = 4'b1111;
      dout = '0; smi_en = 4'b0001; smi_gen = 1'b1; smi_od = 1'b0;
      pme_clr = '0; smi_clr = '0;
      tick(3);
      chk("R1 pme at reset", pme_sts, 4'h0);
      rst_n = 1'b1;
      tick(6);
      chk("R11 no event from level at release", pme_sts, 4'h0);
      chk("R1 smi flags after release", smi_sts, 4'h0);
      chk("R10 pp idle high", {smi_n_oe, smi_n_o}, 2'b11);

      // output drive table on pin 2
      for (int v = 0; v < NVEC; v++) begin
         {cfg_dir[2], cfg_pol[2], cfg_od[2], dout[2]} = DRV_VEC[v][5:2];
         #1;
         chk("R3 drive", {pad_o[2], pad_oe[2]}, DRV_VEC[v][1:0]);
      end
      cfg_dir = '0; cfg_pol = '0; cfg_od = '0; dout = '0;

      // input path and rising edge on pin 3, pin 0 inverted
      cfg_pol = 4'b0001;
      pad_i[3] = 1'b1;
      tick(1);
      chk("R2 not yet visible", pin_val[3], 1'b0);
      tick(1);
      chk("R2 pin value", pin_val, 4'b1011);
      chk("R4 not set early", pme_sts, 4'h0);
      tick(1);
      chk("R4 rise pme", pme_sts, 4'b1000);
      chk("R4 rise smi", smi_sts, 4'b1000);
      chk("R8 masked off", smi_n_o, 1'b1);
      smi_en = 4'b1000; #1;
      chk("R8 R10 active pp", {smi_n_oe, smi_n_o}, 2'b10);
      smi_gen = 1'b0; #1;
      chk("R8 global off", {smi_n_oe, smi_n_o}, 2'b11);
      smi_gen = 1'b1; smi_od = 1'b1; #1;
      chk("R9 active od", {smi_n_oe, smi_n_o}, 2'b10);
      smi_en = 4'b0000; #1;
      chk("R9 idle od released", smi_n_oe, 1'b0);
      smi_od = 1'b0; smi_en = 4'b1000;

      // write-one-to-clear
      pme_clr = 4'b1001;
      tick(1);
      pme_clr = '0;
      chk("R6 pme cleared", pme_sts, 4'h0);
      chk("R6 smi untouched", smi_sts, 4'b1000);
      smi_clr = 4'b1000;
      tick(1);
      smi_clr = '0;
      chk("R6 smi cleared", smi_sts, 4'h0);

      // falling edges with polarity inverted, pin 1 detection disabled
      cfg_pol = 4'b1111; edge_en = 4'b1101;
      pad_i = 4'b0000;
      tick(3);
      chk("R5 R4 fall under inversion", pme_sts, 4'b1000);
      chk("R4 disabled pin quiet", smi_sts, 4'b1000);
      tick(5);
      chk("R6 sticky", pme_sts, 4'b1000);

      // set beats clear on the same edge
      pad_i[3] = 1'b1;
      tick(2);
      pme_clr = 4'b1000; smi_clr = 4'b1000;
      tick(1);
      pme_clr = '0; smi_clr = '0;
      chk("R7 pme set wins", pme_sts, 4'b1000);
      chk("R7 smi set wins", smi_sts, 4'b1000);
      pme_clr = 4'b1000;
      tick(1);
      pme_clr = '0;
      chk("R6 clear after", pme_sts, 4'h0);

      finish_run();
   end
endmodule